// File: doc/BRIEF.md
# Software Run Verdict Monitor

This block sits beside a small processor core. It observes the data-memory store port and the instruction word being fetched each cycle, and turns what the program does into a verdict for a self-checking testbench. The program reports its result by storing a code to one fixed status address. It ends by fetching a branch that loops back to itself. On that halt fetch the monitor raises `done`, freezes its cycle counter and presents pass or fail, the stored code, and whether any code was reported at all.

Code 1 means success. Codes 2 (wrong result) and 3 (item not found) are the usual failure codes. Any other value is also a failure and is kept as it was written so the bench can print it. If the program halts without storing a code, the run fails and a separate flag marks the missing report. The monitor contains no printing and no timeout. The bench reads its flags and registers.

Top module: `run_verdict_monitor`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `done`, `pass`, `fail` and `no_report` are 0, and `code` and `cycles` are 0.
- R2: A store (`st_en` high at a rising edge) is taken as a status report when bits [31:2] of `st_addr` equal those of byte address 4092. Bits [1:0] are ignored, so 4092 to 4095 all match. The stored `st_data` appears on `code` after that edge. Stores to any other word (for example 4088 or 4096) leave `code` and the reported state unchanged.
- R3: A later status store replaces the code from an earlier one.
- R4: `done` rises at the rising edge where `fetch_word` equals 32'h00000063, the branch-if-equal of register 0 with itself and zero offset. Any other fetched word, including the same branch with a nonzero offset, does not set `done`.
- R5: `cycles` counts every rising edge after reset release while `done` is low, including the halt edge. A program that halts on its k-th fetched word therefore shows `cycles` = k. The count holds once `done` is high.
- R6: `pass` is 1 only when `done` is high, a status store was seen, and `code` equals 1.
- R7: `fail` is 1 exactly when `done` is high and `pass` is 0. This covers codes 2, 3, any other value, and the no-report case.
- R8: `no_report` is 1 when `done` is high and no status store was accepted since reset. `code` then reads 0.
- R9: A status store on the same edge as the halt fetch is accepted. Status stores after `done` is high have no effect on `code` or the verdict.
- R10: Once high, `done` stays high until reset, and reset returns the monitor to its R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_en | input | 1 | Data-memory store strobe |
| st_addr | input | ADDR_W (32) | Store byte address |
| st_data | input | 32 | Store data |
| fetch_word | input | 32 | Instruction word fetched this cycle |
| done | output | 1 | Halt seen; run finished |
| pass | output | 1 | Finished with code 1 reported |
| fail | output | 1 | Finished without a pass |
| no_report | output | 1 | Finished without any status store |
| code | output | 32 | Last accepted status code |
| cycles | output | CNT_W (32) | Cycles from reset release to halt |

## Verification
The bench aims at off-by-one errors in the cycle count. A counter that skipped the halt edge, or kept running after it, would report k-1 or a growing number. It stores to neighbouring words and to the byte addresses that share the status word. A decoder that compared all address bits would miss 4094, and one that compared too few would accept 4088. It sends near-miss branch words to catch a halt decoder that ignores the offset field. It also covers stores on the halt edge and after it, where a monitor with the wrong gating would either drop a final report or let a late store flip the verdict. A missing report must give a fail with `no_report` set, not a pass on a stale code.

// File: rtl/run_verdict_monitor.sv
module run_verdict_monitor #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32,
  parameter int STATUS_ADDR = 4092,
  parameter logic [31:0] HALT_WORD = 32'h0000_0063,
  parameter logic [31:0] PASS_CODE = 32'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [31:0]       st_data,
  input  logic [31:0]       fetch_word,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              no_report,
  output logic [31:0]       code,
  output logic [CNT_W-1:0]  cycles
);
  localparam logic [ADDR_W-1:0] STATUS_BYTE = ADDR_W'(STATUS_ADDR);

  logic reported;
  logic status_hit;
  logic halt_hit;

  assign status_hit = st_en && !done &&
                      (st_addr[ADDR_W-1:2] == STATUS_BYTE[ADDR_W-1:2]);
  assign halt_hit   = (fetch_word == HALT_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code     <= '0;
      reported <= 1'b0;
    end else if (status_hit) begin
      code     <= st_data;
      reported <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      cycles <= '0;
    end else if (!done) begin
      cycles <= cycles + 1'b1;
      if (halt_hit) done <= 1'b1;
    end
  end

  assign pass      = done && reported && (code == PASS_CODE);
  assign fail      = done && !pass;
  assign no_report = done && !reported;
endmodule

// File: rtl/run_verdict_monitor_chk.sv
module run_verdict_monitor_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      fetch_word,
  input logic             done,
  input logic             pass,
  input logic             fail,
  input logic [31:0]      code,
  input logic [CNT_W-1:0] cycles
);
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  p_count_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(cycles));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (cycles == $past(cycles) + 1'b1));

  p_halt_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && fetch_word == 32'h0000_0063) |=> done);

  p_code_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(code));

  p_verdict_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pass, fail}) == (done ? 1 : 0));
endmodule

bind run_verdict_monitor run_verdict_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .done(done),
  .pass(pass), .fail(fail), .code(code), .cycles(cycles)
);

// File: tb/test_run_verdict_monitor.sv
module test_run_verdict_monitor;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] NOP  = 32'h0000_0013;
  localparam logic [31:0] HALT = 32'h0000_0063;
  localparam logic [31:0] SA   = 32'd4092;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_en = 1'b0;
  logic [31:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic [31:0] fetch_word = NOP;
  logic done, pass, fail, no_report;
  logic [31:0] code;
  logic [31:0] cycles;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  run_verdict_monitor i_run_verdict_monitor (
    .clk(clk), .rst_n(rst_n), .st_en(st_en), .st_addr(st_addr),
    .st_data(st_data), .fetch_word(fetch_word), .done(done), .pass(pass),
    .fail(fail), .no_report(no_report), .code(code), .cycles(cycles)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; st_en = 1'b0; fetch_word = NOP;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic [31:0] w, input logic we,
                      input logic [31:0] a, input logic [31:0] d);
    fetch_word = w; st_en = we; st_addr = a; st_data = d;
    @(negedge clk);
    st_en = 1'b0; fetch_word = NOP;
  endtask

  task automatic verdict(input string req, input logic p, input logic f,
                         input logic nr, input logic [31:0] c);
    chk({req, " done"}, 32'(done), 32'd1);
    chk({req, " pass"}, 32'(pass), 32'(p));
    chk({req, " fail"}, 32'(fail), 32'(f));
    chk({req, " no_report"}, 32'(no_report), 32'(nr));
    chk({req, " code"}, code, c);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 done", 32'(done), 0);
    chk("R1 pass", 32'(pass), 0);
    chk("R1 fail", 32'(fail), 0);
    chk("R1 no_report", 32'(no_report), 0);
    chk("R1 code", code, 0);
    chk("R1 cycles", cycles, 0);
  endtask

  task automatic t_pass();
    do_reset();
    for (int i = 0; i < 3; i++) step(NOP, 0, 0, 0);
    step(NOP, 1, SA, 1);
    step(NOP, 0, 0, 0);
    chk("R4 done before halt", 32'(done), 0);
    step(HALT, 0, 0, 0);
    verdict("R6", 1, 0, 0, 1);
    chk("R5 cycles at halt", cycles, 6);
  endtask

  task automatic t_fail_codes();
    logic [31:0] cs [3] = '{32'd2, 32'd3, 32'hDEAD_0007};
    foreach (cs[k]) begin
      do_reset();
      step(NOP, 1, SA, cs[k]);
      step(HALT, 0, 0, 0);
      verdict("R7", 0, 1, 0, cs[k]);
    end
  endtask

  task automatic t_no_report();
    do_reset();
    step(HALT, 0, 0, 0);
    verdict("R8", 0, 1, 1, 0);
    chk("R5 first-word halt", cycles, 1);
  endtask

  task automatic t_overwrite();
    do_reset();
    step(NOP, 1, SA, 2);
    step(NOP, 1, SA, 1);
    step(HALT, 0, 0, 0);
    verdict("R3 fail->pass", 1, 0, 0, 1);
    do_reset();
    step(NOP, 1, SA, 1);
    step(NOP, 1, SA, 3);
    step(HALT, 0, 0, 0);
    verdict("R3 pass->fail", 0, 1, 0, 3);
  endtask

  task automatic t_address();
    do_reset();
    step(NOP, 1, 32'd4088, 1);
    step(NOP, 1, 32'd4096, 1);
    step(NOP, 1, 32'h0001_0FFC, 1);
    chk("R2 other words code", code, 0);
    step(HALT, 0, 0, 0);
    verdict("R2 other words", 0, 1, 1, 0);
    do_reset();
    step(NOP, 1, 32'd4094, 1);
    step(HALT, 0, 0, 0);
    verdict("R2 byte offset", 1, 0, 0, 1);
  endtask

  task automatic t_after_done();
    do_reset();
    step(NOP, 0, 0, 0);
    step(HALT, 1, SA, 1);
    verdict("R9 store on halt edge", 1, 0, 0, 1);
    chk("R5 cycles", cycles, 2);
    step(NOP, 1, SA, 2);
    step(HALT, 1, SA, 5);
    for (int i = 0; i < 4; i++) step(NOP, 0, 0, 0);
    verdict("R9 late stores", 1, 0, 0, 1);
    chk("R5 frozen", cycles, 2);
    chk("R10 sticky", 32'(done), 1);
    t_reset();
  endtask

  task automatic t_near_halt();
    do_reset();
    step(32'h0000_0863, 0, 0, 0);
    step(32'h0010_0063, 0, 0, 0);
    step(32'h0000_0067, 0, 0, 0);
    step(32'h8000_0063, 0, 0, 0);
    chk("R4 near-miss words", 32'(done), 0);
    chk("R5 running count", cycles, 4);
    step(HALT, 0, 0, 0);
    chk("R4 exact word", 32'(done), 1);
    chk("R5 count", cycles, 5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pass();
    t_fail_codes();
    t_no_report();
    t_overwrite();
    t_address();
    t_after_done();
    t_near_halt();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule